// File: doc/BRIEF.md
# Automatic Level Control Gain Controller

This block closes a digital loop around an input amplifier. It watches the signed samples coming back from an ADC and moves a 6-bit gain code so that the signal level settles near a programmable target. One gain step is 0.75 dB, and the code rises toward the loudest setting. When a sample's magnitude exceeds the target, the controller enters an attack phase and steps the gain down at a rate set by the attack setting. Once the loudest sample over a whole interval lies at least 1.5 dB below the target, it stops cutting. It then waits out a hold time and enters a decay phase. In the decay phase the gain climbs back one code per decay interval, for as long as the level stays under that 1.5 dB line.

Two modes are supported. In the normal mode the gain ranges between a programmed floor and a programmed ceiling. In the limiter mode the programmed ceiling is ignored. Instead, the gain in force at the moment the limiter became active is frozen as the ceiling, and the attack and decay intervals are shortened by a fixed power of two. The floor applies in both modes. The threshold 1.5 dB below the target is the target times 0.84375. It is formed with shifts and subtractions only.

Top module: `alc_gain_ctrl`

## Requirements
- R1: In normal mode (`lim_mode` = 0) the gain code never rises above `max_gain`. A value outside the range is clamped on the next enabled clock.
- R2: When `en` and `lim_mode` are both high for the first time after being otherwise, the current gain code becomes the ceiling. While the limiter stays active, the gain never goes above that ceiling, and `max_gain` has no effect, even when it is lower than the gain.
- R3: `min_gain` is a floor that applies in both modes. If the floor and the ceiling conflict, the floor wins.
- R4: A sample is loud when its two's-complement magnitude is greater than `target_lvl`. The most negative code has a magnitude of 2^(SAMPLE_W-1). A loud sample starts or continues the attack phase, and the first loud sample counts as sample 1. Each time ATK_UNIT<<`atk_rate` samples have been counted in the attack phase, the gain drops by one code.
- R5: At the end of each attack interval, the controller looks at the peak magnitude over that interval. If the peak is at or below the low threshold `target_lvl - (target_lvl>>3) - (target_lvl>>5)`, the controller stops cutting and enters the hold phase instead of stepping. The peak is cleared after every interval decision.
- R6: The hold phase lasts `hold_rate`*HOLD_UNIT samples (at least one sample) before the decay phase starts. A loud sample during hold goes straight back to attack.
- R7: In the decay phase, the end of every DCY_UNIT<<`dcy_rate` sample interval raises the gain by one code, but only if the interval's peak is at or below the low threshold. A peak between the low threshold and the target leaves the gain unchanged.
- R8: While the limiter is active, both the attack interval and the decay interval are shifted right by LIM_SHIFT, with a minimum of one sample. The hold length is not shortened.
- R9: While `en` is low the gain code is frozen and samples are ignored. The phase returns to hold, and the counter and the peak are cleared.
- R10: Synchronous reset sets the gain code to INIT_GAIN and the phase to hold. A gain change appears on `gain_code` at the clock edge that captures the valid sample causing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Loop enable |
| lim_mode | input | 1 | 0 = normal mode, 1 = limiter mode |
| smp_vld | input | 1 | ADC sample strobe |
| smp_data | input | SAMPLE_W | Signed ADC sample |
| target_lvl | input | SAMPLE_W-1 | Target magnitude |
| max_gain | input | GAIN_W | Normal-mode ceiling |
| min_gain | input | GAIN_W | Floor for both modes |
| atk_rate | input | RATE_W | Attack interval exponent |
| dcy_rate | input | RATE_W | Decay interval exponent |
| hold_rate | input | HOLD_W | Hold length in HOLD_UNIT samples |
| gain_code | output | GAIN_W | Registered amplifier gain code |

## Verification
Each gain change is due at the clock edge that captures the sample which completes an interval. The bench therefore presents every sample for exactly one clock and samples `gain_code` on the following falling edge. It counts samples, not cycles, to predict when steps occur. It expects the attack step on the ATK_UNIT<<rate-th loud sample, the hold-to-decay handover after the hold count, and each decay step after a full decay interval. Checks are placed one sample before and on the predicted sample. A change of mode or ceiling is applied between samples. The bench then reads the latched limiter ceiling only after the edge that captured it.

// File: rtl/alc_pkg.sv
package alc_pkg;

    typedef enum logic [1:0] {
        PH_HOLD   = 2'd0,
        PH_ATTACK = 2'd1,
        PH_DECAY  = 2'd2
    } alc_phase_e;

    // Per-sample action requested by the phase machine
    typedef struct packed {
        logic step_dn;
        logic step_up;
        logic clr_peak;
    } alc_step_t;

    // Interval lengths handed from the selector to the phase machine
    typedef struct packed {
        logic [31:0] atk;
        logic [31:0] dcy;
        logic [31:0] hold;
    } alc_span_t;

    // Level 1.5 dB below target: t * (1 - 1/8 - 1/32) = 0.84375 t
    function automatic logic [31:0] low_thresh(input logic [31:0] t);
        return t - (t >> 3) - (t >> 5);
    endfunction

    // Interval in samples: unit << rate, optionally shortened, never below one
    function automatic logic [31:0] span_len(input logic [31:0] unit,
                                             input logic [4:0]  rate,
                                             input logic        fast,
                                             input logic [4:0]  shift);
        logic [31:0] v;
        v = unit << rate;
        if (fast)
            v = v >> shift;
        if (v == 32'd0)
            v = 32'd1;
        return v;
    endfunction

    // Two's complement magnitude, one bit wider than needed for the sign-free range
    function automatic logic [31:0] mag32(input logic [31:0] s, input logic neg);
        return neg ? (~s + 32'd1) : s;
    endfunction

endpackage

// File: rtl/alc_level_detect.sv
module alc_level_detect
    import alc_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                smp_vld,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [SAMPLE_W-2:0] target_lvl,
    input  logic                clr_peak,
    output logic                loud,
    output logic                quiet
);
    logic [SAMPLE_W-1:0] mag;
    logic [SAMPLE_W-1:0] peak_q;
    logic [SAMPLE_W-1:0] peak_nxt;
    logic [SAMPLE_W-1:0] tgt_w;
    logic [SAMPLE_W-1:0] low_w;
    logic [31:0]         mag_full;
    logic [31:0]         low_full;

    always_comb begin
        mag_full = mag32({{(32-SAMPLE_W){smp_data[SAMPLE_W-1]}}, smp_data},
                         smp_data[SAMPLE_W-1]);
        mag      = mag_full[SAMPLE_W-1:0];
        tgt_w    = {1'b0, target_lvl};
        low_full = low_thresh({{(33-SAMPLE_W){1'b0}}, target_lvl});
        low_w    = low_full[SAMPLE_W-1:0];
        peak_nxt = (mag > peak_q) ? mag : peak_q;
        loud     = mag > tgt_w;
        quiet    = peak_nxt <= low_w;
    end

    always_ff @(posedge clk) begin
        if (rst || !en)
            peak_q <= '0;
        else if (smp_vld)
            peak_q <= clr_peak ? '0 : peak_nxt;
    end

endmodule

// File: rtl/alc_interval_sel.sv
module alc_interval_sel
    import alc_pkg::*;
#(
    parameter int RATE_W    = 4,
    parameter int HOLD_W    = 4,
    parameter int ATK_UNIT  = 4,
    parameter int DCY_UNIT  = 8,
    parameter int HOLD_UNIT = 4,
    parameter int LIM_SHIFT = 2
) (
    input  logic              fast,
    input  logic [RATE_W-1:0] atk_rate,
    input  logic [RATE_W-1:0] dcy_rate,
    input  logic [HOLD_W-1:0] hold_rate,
    output alc_span_t         spans
);
    localparam logic [4:0] SHIFT_C = 5'(LIM_SHIFT);
    localparam int         N_LANE  = 2;

    logic [31:0] lane_len [N_LANE];
    logic [31:0] hold_raw;

    // Lane 0 = attack, lane 1 = decay; both share the limiter shortening
    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        localparam logic [31:0] UNIT_C = (g == 0) ? 32'(ATK_UNIT) : 32'(DCY_UNIT);
        logic [RATE_W-1:0] rate_sel;
        assign rate_sel    = (g == 0) ? atk_rate : dcy_rate;
        assign lane_len[g] = span_len(UNIT_C, 5'(rate_sel), fast, SHIFT_C);
    end

    always_comb begin
        hold_raw    = 32'(hold_rate) * 32'(HOLD_UNIT);
        spans.atk   = lane_len[0];
        spans.dcy   = lane_len[1];
        spans.hold  = (hold_raw == 32'd0) ? 32'd1 : hold_raw;
    end

endmodule

// File: rtl/alc_phase_fsm.sv
module alc_phase_fsm
    import alc_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       smp_vld,
    input  logic       loud,
    input  logic       quiet,
    input  alc_span_t  spans,
    output alc_step_t  act,
    output alc_phase_e phase
);
    alc_phase_e       ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] atk_len, dcy_len, hold_len;
    logic             atk_done, dcy_done, hold_done;

    always_comb begin
        atk_len   = spans.atk[CNT_W-1:0];
        dcy_len   = spans.dcy[CNT_W-1:0];
        hold_len  = spans.hold[CNT_W-1:0];
        // A loud sample arriving outside attack restarts the count at one
        cnt_inc   = ((loud && ph_q != PH_ATTACK) ? '0 : cnt_q) + 1'b1;
        atk_done  = cnt_inc >= atk_len;
        dcy_done  = cnt_inc >= dcy_len;
        hold_done = cnt_inc >= hold_len;
    end

    always_comb begin
        ph_d  = ph_q;
        cnt_d = cnt_q;
        act   = '0;
        if (smp_vld) begin
            if (loud) begin
                ph_d = PH_ATTACK;
                if (atk_done) begin
                    act.step_dn  = 1'b1;
                    act.clr_peak = 1'b1;
                    cnt_d        = '0;
                end else begin
                    cnt_d = cnt_inc;
                end
            end else begin
                unique case (ph_q)
                    PH_ATTACK: begin
                        if (atk_done) begin
                            act.clr_peak = 1'b1;
                            cnt_d        = '0;
                            if (quiet)
                                ph_d = PH_HOLD;
                            else
                                act.step_dn = 1'b1;
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end
                    PH_HOLD: begin
                        if (hold_done) begin
                            ph_d         = PH_DECAY;
                            act.clr_peak = 1'b1;
                            cnt_d        = '0;
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end
                    PH_DECAY: begin
                        if (dcy_done) begin
                            act.clr_peak = 1'b1;
                            act.step_up  = quiet;
                            cnt_d        = '0;
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end
                    default: begin
                        ph_d  = PH_HOLD;
                        cnt_d = '0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ph_q  <= PH_HOLD;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
        end
    end

    assign phase = ph_q;

endmodule

// File: rtl/alc_gain_reg.sv
module alc_gain_reg #(
    parameter int GAIN_W    = 6,
    parameter int INIT_GAIN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              lim_mode,
    input  logic [GAIN_W-1:0] max_gain,
    input  logic [GAIN_W-1:0] min_gain,
    input  logic              step_dn,
    input  logic              step_up,
    output logic [GAIN_W-1:0] gain_code,
    output logic              lim_on
);
    localparam logic [GAIN_W-1:0] GAIN_TOP = '1;

    logic [GAIN_W-1:0] gain_q, gain_d;
    logic [GAIN_W-1:0] ceil_q, ceil_eff;
    logic              lim_act, lim_q, lim_rise;

    always_comb begin
        lim_act  = en && lim_mode;
        lim_rise = lim_act && !lim_q;
        if (lim_act)
            ceil_eff = lim_rise ? gain_q : ceil_q;
        else
            ceil_eff = max_gain;

        gain_d = gain_q;
        if (step_dn && gain_q != '0)
            gain_d = gain_q - 1'b1;
        else if (step_up && gain_q != GAIN_TOP)
            gain_d = gain_q + 1'b1;
        if (gain_d > ceil_eff)
            gain_d = ceil_eff;
        if (gain_d < min_gain)
            gain_d = min_gain;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q <= GAIN_W'(INIT_GAIN);
            ceil_q <= GAIN_W'(INIT_GAIN);
            lim_q  <= 1'b0;
        end else begin
            lim_q <= lim_act;
            if (lim_rise)
                ceil_q <= gain_q;
            if (en)
                gain_q <= gain_d;
        end
    end

    assign gain_code = gain_q;
    assign lim_on    = lim_q;

endmodule

// File: rtl/alc_gain_ctrl.sv
module alc_gain_ctrl
    import alc_pkg::*;
#(
    parameter int SAMPLE_W  = 16,
    parameter int GAIN_W    = 6,
    parameter int RATE_W    = 4,
    parameter int HOLD_W    = 4,
    parameter int ATK_UNIT  = 4,
    parameter int DCY_UNIT  = 8,
    parameter int HOLD_UNIT = 4,
    parameter int LIM_SHIFT = 2,
    parameter int INIT_GAIN = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                lim_mode,
    input  logic                smp_vld,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [SAMPLE_W-2:0] target_lvl,
    input  logic [GAIN_W-1:0]   max_gain,
    input  logic [GAIN_W-1:0]   min_gain,
    input  logic [RATE_W-1:0]   atk_rate,
    input  logic [RATE_W-1:0]   dcy_rate,
    input  logic [HOLD_W-1:0]   hold_rate,
    output logic [GAIN_W-1:0]   gain_code
);
    localparam int UNIT_MAX = (ATK_UNIT > DCY_UNIT) ? ATK_UNIT : DCY_UNIT;
    localparam int HOLD_MAX = ((1 << HOLD_W) - 1) * HOLD_UNIT;
    localparam int SPAN_W   = $clog2(UNIT_MAX + 1) + (1 << RATE_W) - 1;
    localparam int HLD_BITS = $clog2(HOLD_MAX + 2);
    localparam int CNT_W    = ((SPAN_W > HLD_BITS) ? SPAN_W : HLD_BITS) + 1;

    logic       loud, quiet, lim_on;
    alc_step_t  act;
    alc_span_t  spans;
    alc_phase_e phase;

    alc_level_detect #(.SAMPLE_W(SAMPLE_W)) u_level (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .smp_vld    (smp_vld),
        .smp_data   (smp_data),
        .target_lvl (target_lvl),
        .clr_peak   (act.clr_peak),
        .loud       (loud),
        .quiet      (quiet)
    );

    alc_interval_sel #(
        .RATE_W    (RATE_W),
        .HOLD_W    (HOLD_W),
        .ATK_UNIT  (ATK_UNIT),
        .DCY_UNIT  (DCY_UNIT),
        .HOLD_UNIT (HOLD_UNIT),
        .LIM_SHIFT (LIM_SHIFT)
    ) u_span (
        .fast      (en && lim_mode),
        .atk_rate  (atk_rate),
        .dcy_rate  (dcy_rate),
        .hold_rate (hold_rate),
        .spans     (spans)
    );

    alc_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .smp_vld (smp_vld),
        .loud    (loud),
        .quiet   (quiet),
        .spans   (spans),
        .act     (act),
        .phase   (phase)
    );

    alc_gain_reg #(
        .GAIN_W    (GAIN_W),
        .INIT_GAIN (INIT_GAIN)
    ) u_gain (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .lim_mode  (lim_mode),
        .max_gain  (max_gain),
        .min_gain  (min_gain),
        .step_dn   (act.step_dn),
        .step_up   (act.step_up),
        .gain_code (gain_code),
        .lim_on    (lim_on)
    );

endmodule

// File: rtl/alc_gain_ctrl_chk.sv
module alc_gain_ctrl_chk #(
    parameter int SAMPLE_W = 16,
    parameter int GAIN_W   = 6
) (
    input logic                clk,
    input logic                rst,
    input logic                en,
    input logic                lim_mode,
    input logic                smp_vld,
    input logic [SAMPLE_W-1:0] smp_data,
    input logic [SAMPLE_W-2:0] target_lvl,
    input logic [GAIN_W-1:0]   max_gain,
    input logic [GAIN_W-1:0]   min_gain,
    input logic [GAIN_W-1:0]   gain_code
);
    // Independent view of the limiter ceiling
    logic              lim_seen;
    logic [GAIN_W-1:0] lim_ceil;
    logic [SAMPLE_W:0] abs_v;
    logic              is_loud;

    always_comb begin
        abs_v   = smp_data[SAMPLE_W-1] ? ({1'b0, ~smp_data} + 1'b1) : {1'b0, smp_data};
        is_loud = abs_v > {2'b00, target_lvl};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_seen <= 1'b0;
            lim_ceil <= '0;
        end else begin
            lim_seen <= en && lim_mode;
            if (en && lim_mode && !lim_seen)
                lim_ceil <= gain_code;
        end
    end

    // R1: a rise in normal mode stays within the programmed ceiling
    p_norm_ceiling_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && !$past(lim_mode) && gain_code > $past(gain_code))
        |-> gain_code <= $past(max_gain));

    // R2: a rise while the limiter was already active stays within the latched gain
    p_lim_ceiling_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(en && lim_mode && lim_seen) && gain_code > $past(gain_code))
        |-> gain_code <= lim_ceil);

    // R3: a fall never goes under the floor
    p_floor_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && gain_code < $past(gain_code))
        |-> gain_code >= $past(min_gain));

    // R4: a loud sample never raises the gain unless the floor forces it
    p_loud_no_rise_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(en && smp_vld && is_loud) && $past(gain_code) >= $past(min_gain))
        |-> gain_code <= $past(gain_code));

    // R9: gain frozen while disabled
    p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> $stable(gain_code));

endmodule

bind alc_gain_ctrl alc_gain_ctrl_chk #(
    .SAMPLE_W (SAMPLE_W),
    .GAIN_W   (GAIN_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .lim_mode   (lim_mode),
    .smp_vld    (smp_vld),
    .smp_data   (smp_data),
    .target_lvl (target_lvl),
    .max_gain   (max_gain),
    .min_gain   (min_gain),
    .gain_code  (gain_code)
);

// File: tb/alc_gain_ctrl_bench.sv
module alc_gain_ctrl_bench;
    localparam int SW = 16;
    localparam int GW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          en;
    logic          lim_mode;
    logic          smp_vld;
    logic [SW-1:0] smp_data;
    logic [SW-2:0] target_lvl;
    logic [GW-1:0] max_gain, min_gain;
    logic [3:0]    atk_rate, dcy_rate, hold_rate;
    logic [GW-1:0] gain_code;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    alc_gain_ctrl u_alc_gain_ctrl (
        .clk(clk), .rst(rst), .en(en), .lim_mode(lim_mode),
        .smp_vld(smp_vld), .smp_data(smp_data), .target_lvl(target_lvl),
        .max_gain(max_gain), .min_gain(min_gain), .atk_rate(atk_rate),
        .dcy_rate(dcy_rate), .hold_rate(hold_rate), .gain_code(gain_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present n samples of one value, each valid for one clock
    task automatic feed(input int val, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_data = SW'(val);
            smp_vld  = 1'b1;
            @(negedge clk);
            smp_vld  = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1; en = 1'b0; lim_mode = 1'b0; smp_vld = 1'b0; smp_data = '0;
        target_lvl = 15'd8000; max_gain = 6'd40; min_gain = 6'd0;
        atk_rate = 4'd0; dcy_rate = 4'd0; hold_rate = 4'd2;
        idle(3);
        chk("R10 reset gain", gain_code, 16);
        rst = 1'b0;
        idle(2);
        chk("R10 gain after reset release", gain_code, 16);
        en = 1'b1;
    endtask

    // Loud: 4 samples per step, negative full scale counts as loud
    task automatic t_attack;
        feed(20000, 3);
        chk("R4 no step before interval", gain_code, 16);
        feed(-32768, 1);
        chk("R4 step on 4th loud sample", gain_code, 15);
        feed(-20000, 3);
        chk("R4 second interval pending", gain_code, 15);
        feed(20000, 1);
        chk("R4 second step", gain_code, 14);
    endtask

    task automatic t_floor;
        min_gain = 6'd12;
        feed(20000, 8);
        chk("R3 reaches floor", gain_code, 12);
        feed(20000, 32);
        chk("R3 holds at floor", gain_code, 12);
    endtask

    // Quiet: 4 attack samples end the cut, 8 hold, then 8 per decay step
    task automatic t_hold_decay;
        feed(1000, 19);
        chk("R5 R6 no rise before hold and decay", gain_code, 12);
        feed(1000, 1);
        chk("R7 first decay step", gain_code, 13);
        max_gain = 6'd15;
        feed(1000, 8);
        chk("R7 second decay step", gain_code, 14);
    endtask

    task automatic t_ceiling;
        feed(1000, 8);
        chk("R1 climbs to ceiling", gain_code, 15);
        feed(1000, 16);
        chk("R1 stays at ceiling", gain_code, 15);
    endtask

    task automatic t_band;
        max_gain = 6'd20;
        feed(7000, 24);
        chk("R7 in-band peak leaves gain", gain_code, 15);
        feed(1000, 8);
        chk("R7 quiet again resumes rise", gain_code, 16);
    endtask

    task automatic t_limiter;
        lim_mode = 1'b1;
        idle(2);
        max_gain = 6'd5;
        feed(1000, 40);
        chk("R2 latched ceiling, max ignored", gain_code, 16);
        feed(20000, 1);
        chk("R8 limiter attack after one sample", gain_code, 15);
        feed(20000, 1);
        chk("R8 limiter attack again", gain_code, 14);
        max_gain = 6'd20;
        lim_mode = 1'b0;
        idle(2);
        lim_mode = 1'b1;
        idle(2);
        feed(1000, 30);
        chk("R2 relatched ceiling on re-entry", gain_code, 14);
    endtask

    task automatic t_disable;
        en = 1'b0;
        idle(1);
        feed(-30000, 10);
        chk("R9 gain frozen while disabled", gain_code, 14);
    endtask

    initial begin
        t_reset();
        t_attack();
        t_floor();
        t_hold_decay();
        t_ceiling();
        t_band();
        t_limiter();
        t_disable();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule